// File: doc/BRIEF.md
# Dual-Accumulator Closed-Loop Multiphase PWM

This block turns an unsigned command word into a set of pulse-width-modulated lines. Both edges of every pulse follow the command. Two matched phase accumulators run at a common nominal rate. A signed error, the command minus a filtered feedback word, speeds one of them up and slows the other down by the same amount. Because the phase gap between the two accumulators is the running sum of their rate difference, the loop contains an integrator. Short disturbances on the command therefore move the outputs very little, while a lasting change shifts the rising and the falling edges straight away.

Each accumulator is tapped at TAPS evenly spaced phase offsets. For each tap, a four-state comparator watches the wrap events of the leading and the lagging accumulator. A line goes high when the lead wraps and low when the lag wraps, so the duty is the phase gap as a fraction of a turn. Two saturation states take over when the gap falls below zero or rises past a full turn. In those states the comparator reports a level outside the normal span, which gives the loop room to pull the gap back. The level codes of all taps are averaged and passed through a first-order IIR filter to form the feedback word. In steady state the loop makes the feedback equal the command, so the duty on every line is the command divided by 2^CMD_W. Lowering `en` freezes the whole loop.

Top module: `dual_nco_pwm`

## Requirements
- R1: While reset is high and on the first cycle after it, every PWM line is 0 and the feedback word is 0.
- R2: For a steady command c, after settling, the high time summed over all TAPS lines in a window of W cycles equals c·TAPS·W/2^CMD_W, within TAPS·W/2^CMD_W (one command LSB).
- R3: Commands 0 and 2^CMD_W−1 settle to duty 0 and (2^CMD_W−1)/2^CMD_W within one LSB. A later mid-range command then settles again under R2.
- R4: Line i rises (2^PHASE_W/NOM_STEP)/TAPS cycles before line i−1, within 8 cycles.
- R5: Each accumulator advances every cycle by a step strictly between 0 and twice the nominal step. With the loop settled, successive rising edges of line 0 are 2^PHASE_W/NOM_STEP cycles apart, within 8.
- R6: A command pulse lasting one cycle, to full scale and back, changes the measured duty of the following window by no more than one LSB.
- R7: With the loop settled on a mid-range command c, the mean of the feedback word over a window is c within ±1.
- R8: While `en` is low, the PWM lines and the feedback word keep their values.
- R9: The feedback word, a signed value, stays within [−2^CMD_W/2, 3·2^CMD_W/2]. It changes by at most (2·2^CMD_W >> FILT_SH)+1 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop advance enable; low holds all state |
| cmd_i | input | CMD_W | Unsigned duty command, full scale 2^CMD_W |
| pwm_o | output | TAPS | Registered PWM lines, evenly phase-shifted |
| fb_o | output | CMD_W+3 | Signed filtered feedback word |

## Verification
The hardest condition to reach from the ports is saturation of the per-tap comparators. In that case the gap between the accumulators leaves the zero-to-full-turn span, and the out-of-range levels must bring it back. The stimulus holds the command at zero and then at full scale for many oscillator periods, which pins the gap at both ends. It then steps to a small command and measures whether the duty comes back to the expected value. The even tap spacing and the oscillator period are measured from edge timestamps with the loop settled at half scale, where the averaged feedback has almost no ripple.

// File: rtl/pwm_loop_pkg.sv
package pwm_loop_pkg;

  // Per-tap phase comparator state; order is the phase-gap order.
  typedef enum logic [1:0] {
    PS_UNDER = 2'd0,  // gap below zero
    PS_LOW   = 2'd1,  // gap in range, line low
    PS_HIGH  = 2'd2,  // gap in range, line high
    PS_OVER  = 2'd3   // gap above a full turn
  } pd_state_e;

  // One step up on a lead wrap, one step down on a lag wrap, hold on both.
  function automatic pd_state_e pd_next(input pd_state_e s,
                                        input logic lead_ev,
                                        input logic lag_ev);
    pd_state_e n;
    n = s;
    if (lead_ev && !lag_ev) begin
      case (s)
        PS_UNDER: n = PS_LOW;
        PS_LOW:   n = PS_HIGH;
        default:  n = PS_OVER;
      endcase
    end else if (lag_ev && !lead_ev) begin
      case (s)
        PS_OVER:  n = PS_HIGH;
        PS_HIGH:  n = PS_LOW;
        default:  n = PS_UNDER;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ACC_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc
);

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= acc + step;
  end

endmodule

// File: rtl/pfd_cell.sv
module pfd_cell
  import pwm_loop_pkg::*;
#(
  parameter int FB_W = 11,
  parameter int FS   = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            lead_msb,
  input  logic            lag_msb,
  output logic            pwm,
  output logic [FB_W-1:0] level
);

  localparam logic [FB_W-1:0] LV_UNDER = FB_W'(-(FS / 2));
  localparam logic [FB_W-1:0] LV_LOW   = '0;
  localparam logic [FB_W-1:0] LV_HIGH  = FB_W'(FS);
  localparam logic [FB_W-1:0] LV_OVER  = FB_W'(FS + FS / 2);

  pd_state_e state;
  logic      lead_d, lag_d;
  logic      lead_ev, lag_ev;

  // A wrap shows as the tap MSB falling (step is below half a turn).
  assign lead_ev = lead_d & ~lead_msb;
  assign lag_ev  = lag_d  & ~lag_msb;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PS_LOW;
      lead_d <= 1'b0;
      lag_d  <= 1'b0;
    end else if (en) begin
      state  <= pd_next(state, lead_ev, lag_ev);
      lead_d <= lead_msb;
      lag_d  <= lag_msb;
    end
  end

  assign pwm = (state == PS_HIGH) || (state == PS_OVER);

  always_comb begin
    case (state)
      PS_UNDER: level = LV_UNDER;
      PS_LOW:   level = LV_LOW;
      PS_HIGH:  level = LV_HIGH;
      default:  level = LV_OVER;
    endcase
  end

endmodule

// File: rtl/fb_filter.sv
module fb_filter #(
  parameter int TAPS = 4,
  parameter int FB_W = 11,
  parameter int K    = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [TAPS-1:0][FB_W-1:0]   lvl,
  output logic signed [FB_W-1:0]      fb
);

  localparam int LOG_M = $clog2(TAPS);
  localparam int SUM_W = FB_W + LOG_M + 1;
  localparam int YQ_W  = FB_W + K + 2;

  logic signed [SUM_W-1:0] sum, avg;
  logic signed [YQ_W-1:0]  yq, yq_nx, rnd;

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) begin
      sum = sum + SUM_W'($signed(lvl[i]));
    end
    avg   = sum >>> LOG_M;
    // yq holds y scaled by 2^K; fb is its rounded integer part.
    yq_nx = yq + YQ_W'(avg) - YQ_W'(fb);
    rnd   = (yq_nx + YQ_W'(1 << (K - 1))) >>> K;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      yq <= '0;
      fb <= '0;
    end else if (en) begin
      yq <= yq_nx;
      fb <= rnd[FB_W-1:0];
    end
  end

endmodule

// File: rtl/dual_nco_pwm.sv
module dual_nco_pwm #(
  parameter int PHASE_W  = 16,
  parameter int CMD_W    = 8,
  parameter int TAPS     = 4,
  parameter int GAIN_SH  = 3,
  parameter int NOM_STEP = 64,
  parameter int FILT_SH  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [CMD_W-1:0]        cmd_i,
  output logic [TAPS-1:0]         pwm_o,
  output logic signed [CMD_W+2:0] fb_o
);

  localparam int FB_W      = CMD_W + 3;
  localparam int ERR_W     = FB_W + 1;
  localparam int ACC_W     = PHASE_W + GAIN_SH;
  localparam int FS        = 1 << CMD_W;
  localparam int TAP_SPACE = (1 << PHASE_W) / TAPS;
  localparam logic [ACC_W-1:0] NOM_ACC = ACC_W'(NOM_STEP) << GAIN_SH;

  logic signed [ERR_W-1:0]   err;
  logic [ACC_W-1:0]          err_ext, step_a, step_b, acc_a, acc_b;
  logic [TAPS-1:0][FB_W-1:0] lvl;

  // Error is applied below the phase LSB: the gain shift becomes fraction bits.
  assign err     = $signed({{(ERR_W-CMD_W){1'b0}}, cmd_i}) - $signed({fb_o[FB_W-1], fb_o});
  assign err_ext = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
  assign step_a  = NOM_ACC + err_ext;
  assign step_b  = NOM_ACC - err_ext;

  phase_accum #(.ACC_W(ACC_W)) u_lead (
    .clk(clk), .rst(rst), .en(en), .step(step_a), .acc(acc_a)
  );

  phase_accum #(.ACC_W(ACC_W)) u_lag (
    .clk(clk), .rst(rst), .en(en), .step(step_b), .acc(acc_b)
  );

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    logic [PHASE_W-1:0] tap_a, tap_b;
    assign tap_a = acc_a[ACC_W-1 -: PHASE_W] + PHASE_W'(i * TAP_SPACE);
    assign tap_b = acc_b[ACC_W-1 -: PHASE_W] + PHASE_W'(i * TAP_SPACE);

    pfd_cell #(.FB_W(FB_W), .FS(FS)) u_pfd (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .lead_msb (tap_a[PHASE_W-1]),
      .lag_msb  (tap_b[PHASE_W-1]),
      .pwm      (pwm_o[i]),
      .level    (lvl[i])
    );
  end

  fb_filter #(.TAPS(TAPS), .FB_W(FB_W), .K(FILT_SH)) u_filt (
    .clk(clk), .rst(rst), .en(en), .lvl(lvl), .fb(fb_o)
  );

endmodule

// File: rtl/dual_nco_pwm_chk.sv
module dual_nco_pwm_chk #(
  parameter int TAPS    = 4,
  parameter int FB_W    = 11,
  parameter int ACC_W   = 19,
  parameter int FS      = 256,
  parameter int K       = 6,
  parameter int NOM_ACC = 512
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic [TAPS-1:0]        pwm,
  input logic signed [FB_W-1:0] fb,
  input logic [ACC_W-1:0]       step_a,
  input logic [ACC_W-1:0]       step_b
);

  localparam int SLEW = ((2 * FS) >> K) + 1;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pwm == '0 && fb == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pwm) && $stable(fb)));

  // R9
  fb_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(fb) >= -(FS / 2)) && (int'(fb) <= FS + FS / 2));

  // R9
  fb_slew_chk: assert property (@(posedge clk) disable iff (rst)
    iabs(int'(fb) - int'($past(fb))) <= SLEW);

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    (step_a != '0) && (step_b != '0) &&
    (int'(step_a) < 2 * NOM_ACC) && (int'(step_b) < 2 * NOM_ACC));

endmodule

bind dual_nco_pwm dual_nco_pwm_chk #(
  .TAPS(TAPS), .FB_W(CMD_W + 3), .ACC_W(PHASE_W + GAIN_SH),
  .FS(1 << CMD_W), .K(FILT_SH), .NOM_ACC(NOM_STEP << GAIN_SH)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .pwm(pwm_o), .fb(fb_o),
  .step_a(step_a), .step_b(step_b)
);

// File: tb/test_dual_nco_pwm.sv
module test_dual_nco_pwm;

  localparam int CLK_PERIOD = 10;
  localparam int TAPS    = 4;
  localparam int CMD_W   = 8;
  localparam int PHASE_W = 16;
  localparam int NOM     = 64;
  localparam int FILT_SH = 6;
  localparam int FS      = 1 << CMD_W;
  localparam int PERIOD  = (1 << PHASE_W) / NOM;
  localparam int WIN     = 8192;
  localparam int SETTLE  = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic [CMD_W-1:0] cmd = '0;
  logic [TAPS-1:0] pwm;
  logic signed [CMD_W+2:0] fb;

  int checks = 0, errors = 0;
  int fb_min = 0, fb_max = 0;
  longint cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;
  always @(negedge clk) if (!rst) begin
    if (int'(fb) < fb_min) fb_min = int'(fb);
    if (int'(fb) > fb_max) fb_max = int'(fb);
  end

  dual_nco_pwm #(
    .PHASE_W(PHASE_W), .CMD_W(CMD_W), .TAPS(TAPS), .GAIN_SH(3),
    .NOM_STEP(NOM), .FILT_SH(FILT_SH)
  ) i_dual_nco_pwm (
    .clk(clk), .rst(rst), .en(en), .cmd_i(cmd), .pwm_o(pwm), .fb_o(fb)
  );

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output longint hi, output longint fsum);
    hi = 0; fsum = 0;
    for (int n = 0; n < WIN; n++) begin
      @(negedge clk);
      hi   += $countones(pwm);
      fsum += longint'(fb);
    end
  endtask

  task automatic run_cmd(input int c, input string tag, input bit fb_chk);
    longint hi, fsum, exp_hi, tol;
    @(negedge clk);
    cmd = CMD_W'(c);
    repeat (SETTLE) @(negedge clk);
    measure(hi, fsum);
    exp_hi = longint'(c) * TAPS * WIN / FS;
    tol    = TAPS * WIN / FS;
    check(labs(hi - exp_hi) <= tol, tag, hi, exp_hi);
    if (fb_chk)
      check(labs(fsum - longint'(c) * WIN) <= WIN, "R7 mean feedback", fsum / WIN, c);
  endtask

  task automatic wait_rise(input int idx, output longint t);
    logic p;
    p = pwm[idx];
    forever begin
      @(negedge clk);
      if (!p && pwm[idx]) break;
      p = pwm[idx];
    end
    t = cycles;
  endtask

  initial begin
    longint t0, t1, hi, fsum, exp_hi;
    logic [TAPS-1:0] pw_snap;
    logic signed [CMD_W+2:0] fb_snap;
    bit held;

    repeat (4) @(negedge clk);
    // R1: reset state
    check(pwm == '0, "R1 pwm in reset", pwm, 0);
    check(fb == '0, "R1 fb in reset", fb, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pwm == '0 && fb == '0, "R1 first cycle after reset", {pwm, fb}, 0);

    run_cmd(128, "R2 duty c=128", 1'b1);
    run_cmd(64,  "R2 duty c=64",  1'b1);
    run_cmd(200, "R2 duty c=200", 1'b1);
    run_cmd(0,   "R3 duty c=0",   1'b0);
    run_cmd(255, "R3 duty c=255", 1'b0);
    run_cmd(32,  "R3 recovery duty c=32", 1'b1);
    run_cmd(128, "R2 duty c=128 again", 1'b1);

    // R4: tap i rises a quarter period ahead of tap i-1
    for (int i = 1; i < TAPS; i++) begin
      wait_rise(i, t0);
      wait_rise(i - 1, t1);
      check(labs((t1 - t0) - PERIOD / TAPS) <= 8, $sformatf("R4 spacing tap %0d", i),
            t1 - t0, PERIOD / TAPS);
    end

    // R5: settled period of line 0
    wait_rise(0, t0);
    wait_rise(0, t1);
    check(labs((t1 - t0) - PERIOD) <= 8, "R5 period", t1 - t0, PERIOD);

    // R6: one-cycle glitch to full scale
    @(negedge clk); cmd = CMD_W'(FS - 1);
    @(negedge clk); cmd = CMD_W'(128);
    measure(hi, fsum);
    exp_hi = 128 * TAPS * WIN / FS;
    check(labs(hi - exp_hi) <= TAPS * WIN / FS, "R6 glitch", hi, exp_hi);

    // R8: enable low freezes outputs
    @(negedge clk);
    en = 1'b0;
    pw_snap = pwm; fb_snap = fb;
    held = 1'b1;
    repeat (400) begin
      @(negedge clk);
      if (pwm != pw_snap || fb != fb_snap) held = 1'b0;
    end
    check(held, "R8 hold while disabled", {pwm, fb}, {pw_snap, fb_snap});
    en = 1'b1;

    // R9: feedback range over the whole run
    check(fb_min >= -(FS / 2), "R9 feedback min", fb_min, -(FS / 2));
    check(fb_max <= FS + FS / 2, "R9 feedback max", fb_max, FS + FS / 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual %0d expected done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule